// File: doc/BRIEF.md
# Serial Write-Only Control Port with Pin-Selected Mode

This block is the write side of a device control port that is reached over a three-wire serial link: a shared select pin, a serial clock and a serial data input. The select pin also serves as an address-strap pin. The port stays dormant after reset. It becomes a serial control port only when that pin is seen high and then driven low. Once this happens the mode is kept until the next reset, and the pin acts from then on as an active-low frame select.

Inside a frame, bits on the data line are taken on rising edges of the serial clock, most significant bit first. The first byte is a fixed device identifier, and a frame whose identifier does not match is ignored. The second byte sets the register pointer and the auto-increment flag. Every byte after that is stored in the register bank at the pointer. The three pins are asynchronous to the system clock, so the block samples them through synchronizers. It has no output path on the serial side. The stored bank is exposed as a flat vector, and each write is reported with a one-cycle strobe.

Top module: `spi_ctl_port`

## Requirements
- R1: After reset `spi_mode` is 0. It becomes 1 within a few system clocks of the first high-to-low transition of `sel_n` that follows a high level observed after reset. Once set, it stays 1 whatever `sel_n` does, until the next reset.
- R2: Before `spi_mode` is 1, activity on `ser_clk` and `ser_din` causes no register write and leaves the bank unchanged.
- R3: The first byte of a frame must equal the identifier `CHIP_ID` (default 8'h30). If it does not, the rest of the frame up to the rise of `sel_n` writes nothing.
- R4: The second byte is the pointer byte. Bit 7 is the auto-increment flag (1 = enabled) and bits 6:0 are the register address.
- R5: Each later byte is stored in register `ptr`, at `regs_flat[8*ptr +: 8]`. In the same cycle `wr_en` pulses high for one clock, with `wr_addr`=ptr and `wr_data` holding the byte.
- R6: When auto-increment is enabled, the pointer advances by one (modulo 128) after each data byte.
- R7: When auto-increment is disabled, every data byte in the frame overwrites the same register.
- R8: If `sel_n` rises in the middle of a byte, the partial byte is dropped and the bit count is cleared. The next frame begins again with the identifier byte.
- R9: A data byte whose pointer is `NUM_REGS` or higher changes no register and gives no `wr_en` pulse.
- R10: While and after reset, every register and `wr_en` read 0.
- R11: Serial bits are sampled only on rising edges of `ser_clk`, and bytes are assembled MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Shared strap / active-low frame select pin |
| ser_clk | input | 1 | Serial clock; data sampled on its rising edge |
| ser_din | input | 1 | Serial data, MSB first |
| spi_mode | output | 1 | Serial mode has been selected |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 7 | Register address of the current write |
| wr_data | output | 8 | Byte written |
| regs_flat | output | 8*NUM_REGS | Register bank, register i at bits 8*i+7:8*i |

## Verification
Several properties are checked on every cycle. The mode flag never drops once set. No strobe appears before the mode is selected. Every strobe is a single cycle long, carries an in-range address, and matches the bank contents at that address. The bank changes only in cycles with a strobe. Only the bench scenarios can show the byte-level sequencing: identifier rejection, pointer and auto-increment decoding, overwriting in place, and recovery after a frame is cut off mid-byte. These depend on whole serial frames, so the bench compares the bank against its own model after each frame.

// File: rtl/spi_ctl_port.sv
module spi_ctl_port #(
  parameter int          NUM_REGS = 16,
  parameter logic [7:0]  CHIP_ID  = 8'h30
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel_n,
  input  logic                    ser_clk,
  input  logic                    ser_din,
  output logic                    spi_mode,
  output logic                    wr_en,
  output logic [6:0]              wr_addr,
  output logic [7:0]              wr_data,
  output logic [8*NUM_REGS-1:0]   regs_flat
);
  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  typedef enum logic [1:0] {PH_ID, PH_PTR, PH_DATA, PH_SKIP} phase_t;

  logic [2:0] sel_q, sck_q;
  logic [1:0] din_q;
  phase_t     phase;
  logic [2:0] bit_cnt;
  logic [6:0] shreg;
  logic [6:0] ptr;
  logic       auto_inc;
  logic [7:0] bank [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      sck_q <= '0;
      din_q <= '0;
    end else begin
      sel_q <= {sel_q[1:0], sel_n};
      sck_q <= {sck_q[1:0], ser_clk};
      din_q <= {din_q[0], ser_din};
    end
  end

  wire sel_high  = sel_q[1];
  wire sel_fall  = ~sel_q[1] & sel_q[2];
  wire sck_rise  = sck_q[1] & ~sck_q[2];
  wire bit_ok    = spi_mode & ~sel_high & sck_rise & (phase != PH_SKIP);
  wire byte_done = bit_ok & (bit_cnt == 3'd7);
  wire [7:0] byte_in = {shreg, din_q[1]};
  wire ptr_hit   = int'(ptr) < NUM_REGS;
  wire do_write  = byte_done & (phase == PH_DATA) & ptr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) spi_mode <= 1'b0;
    else if (sel_fall) spi_mode <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_ID;
      bit_cnt  <= '0;
      shreg    <= '0;
      ptr      <= '0;
      auto_inc <= 1'b0;
    end else if (sel_high) begin
      phase   <= PH_ID;
      bit_cnt <= '0;
    end else if (bit_ok) begin
      bit_cnt <= bit_cnt + 3'd1;
      shreg   <= byte_in[6:0];
      if (byte_done) begin
        case (phase)
          PH_ID:   phase <= (byte_in == CHIP_ID) ? PH_PTR : PH_SKIP;
          PH_PTR: begin
            ptr      <= byte_in[6:0];
            auto_inc <= byte_in[7];
            phase    <= PH_DATA;
          end
          PH_DATA: if (auto_inc) ptr <= ptr + 7'd1;
          default: phase <= PH_SKIP;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= '0;
    end else begin
      wr_en <= do_write;
      if (do_write) begin
        wr_addr           <= ptr;
        wr_data           <= byte_in;
        bank[ptr[IW-1:0]] <= byte_in;
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_flat[8*g +: 8] = bank[g];
  end
endmodule

module spi_ctl_port_chk #(
  parameter int NUM_REGS = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  spi_mode,
  input logic                  wr_en,
  input logic [6:0]            wr_addr,
  input logic [7:0]            wr_data,
  input logic [8*NUM_REGS-1:0] regs_flat
);
  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) spi_mode |=> spi_mode); // R1
  AST_NO_WR_BEFORE_MODE: assert property (@(posedge clk) disable iff (!rst_n) !spi_mode |-> !wr_en); // R2
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !wr_en); // R5
  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> (int'(wr_addr) < NUM_REGS)); // R9
  AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> (regs_flat[int'(wr_addr)*8 +: 8] == wr_data)); // R5
  AST_BANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |-> $stable(regs_flat)); // R3
endmodule

bind spi_ctl_port spi_ctl_port_chk #(.NUM_REGS(NUM_REGS)) u_chk (.*);

// File: tb/spi_ctl_port_tb.sv
module spi_ctl_port_tb;
  localparam int NR = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, ser_clk = 1'b0, ser_din = 1'b0;
  logic spi_mode, wr_en;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;
  logic [8*NR-1:0] regs_flat;

  int checks = 0, failures = 0, wr_count = 0;
  logic [7:0] model [NR];

  spi_ctl_port #(.NUM_REGS(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .spi_mode(spi_mode), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .regs_flat(regs_flat));

  always #4 clk = ~clk;

  always @(posedge clk) if (wr_en) wr_count <= wr_count + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_bank(input string req);
    for (int i = 0; i < NR; i++) check(req, 32'(regs_flat[8*i +: 8]), 32'(model[i]));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); ser_din = b; ser_clk = 1'b0;
    idle(4);
    ser_clk = 1'b1;
    idle(4);
    ser_din = ~b;
    ser_clk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic frame_start();
    @(negedge clk); sel_n = 1'b0; idle(6);
  endtask

  task automatic frame_end();
    idle(8); sel_n = 1'b1; idle(8);
  endtask

  task automatic t_reset();
    check("R10 wr_en", 32'(wr_en), 0);
    check("R1 mode after reset", 32'(spi_mode), 0);
    check_bank("R10 bank");
  endtask

  task automatic t_pre_mode();
    int w0 = wr_count;
    send_byte(8'h30); send_byte(8'h01); send_byte(8'hFF);
    idle(8);
    check("R2 mode", 32'(spi_mode), 0);
    check("R2 writes", 32'(wr_count - w0), 0);
    check_bank("R2 bank");
  endtask

  task automatic t_first_frame();
    int w0 = wr_count;
    frame_start();
    check("R1 mode set", 32'(spi_mode), 1);
    send_byte(8'h30); send_byte(8'h02); send_byte(8'hA5);
    frame_end();
    model[2] = 8'hA5;
    check("R1 mode held", 32'(spi_mode), 1);
    check("R5 writes", 32'(wr_count - w0), 1);
    check("R11 R5 reg2", 32'(regs_flat[8*2 +: 8]), 32'hA5);
    check_bank("R4 bank");
  endtask

  task automatic t_auto_inc();
    int w0 = wr_count;
    frame_start();
    send_byte(8'h30); send_byte(8'h84);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
    frame_end();
    model[4] = 8'h11; model[5] = 8'h22; model[6] = 8'h33;
    check("R6 writes", 32'(wr_count - w0), 3);
    check_bank("R6 bank");
  endtask

  task automatic t_no_inc();
    int w0 = wr_count;
    frame_start();
    send_byte(8'h30); send_byte(8'h07); send_byte(8'h5A); send_byte(8'hC3);
    frame_end();
    model[7] = 8'hC3;
    check("R7 writes", 32'(wr_count - w0), 2);
    check("R7 reg7", 32'(regs_flat[8*7 +: 8]), 32'hC3);
    check_bank("R7 bank");
  endtask

  task automatic t_bad_id();
    int w0 = wr_count;
    frame_start();
    send_byte(8'h31); send_byte(8'h01); send_byte(8'hEE); send_byte(8'h30);
    frame_end();
    check("R3 writes", 32'(wr_count - w0), 0);
    check_bank("R3 bank");
    sel_n = 1'b0; idle(8); sel_n = 1'b1; idle(8);
    check("R1 mode after toggles", 32'(spi_mode), 1);
  endtask

  task automatic t_abort();
    int w0 = wr_count;
    frame_start();
    send_byte(8'h30); send_byte(8'h09);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    frame_end();
    frame_start();
    send_byte(8'h30); send_byte(8'h0A); send_byte(8'h66);
    frame_end();
    model[10] = 8'h66;
    check("R8 writes", 32'(wr_count - w0), 1);
    check("R8 reg9", 32'(regs_flat[8*9 +: 8]), 0);
    check_bank("R8 bank");
  endtask

  task automatic t_range();
    int w0 = wr_count;
    frame_start();
    send_byte(8'h30); send_byte(8'h14); send_byte(8'h99);
    frame_end();
    check("R9 out of range", 32'(wr_count - w0), 0);
    frame_start();
    send_byte(8'h30); send_byte(8'h8F); send_byte(8'h01); send_byte(8'h02);
    frame_end();
    model[15] = 8'h01;
    check("R9 wrap writes", 32'(wr_count - w0), 1);
    check_bank("R9 bank");
  endtask

  initial begin
    for (int i = 0; i < NR; i++) model[i] = 8'h00;
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(6);
    t_reset();
    t_pre_mode();
    t_first_frame();
    t_auto_inc();
    t_no_inc();
    t_bad_id();
    t_abort();
    t_range();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule